// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

A watchdog timer peripheral clocked by a slow tick. Software programs it through a simple 32-bit register port with byte offsets. A free-running counter is divided by a programmable power of two. The resulting 16-bit scaled count is compared with a threshold. When the scaled count reaches or passes the threshold, the block sets a sticky pending flag that drives the interrupt line. It can also clear the counter automatically and emit a one-cycle system reset pulse.

Every write to the settings, threshold or restart register must come directly after a write of the unlock word to the key register. Each such write uses up the unlock, whether or not it changed anything. Software keeps the system alive by writing a second magic word to the restart register, which zeroes the counter. A mode selection picks between counting on every tick and counting only while the core reports that it is awake.

Top module: `wdog_keyed`

## Requirements
- R1: After a synchronous active-low reset, the settings, threshold and counter are all zero, the unlock is closed, and both `irq_out` and `rst_pulse` are low.
- R2: Writing 0x0051F15E to the key register (offset 0x1C) opens the unlock, and writing any other value to it closes the unlock. A read of the key register returns 1 while the unlock is open and 0 while it is closed.
- R3: A write to a protected register (settings 0x00, restart 0x18, threshold 0x20) takes effect only while the unlock is open. Any write to one of these three offsets closes the unlock. Writes to the read-only offsets leave both the unlock and the counter unchanged.
- R4: A write of exactly 0x0D09F00D to the restart register while the unlock is open clears the counter on that clock edge. Any other restart value, and any restart write while the unlock is closed, leaves the counter unchanged.
- R5: Settings bit 12 makes the counter advance by one on every tick. Settings bit 13 makes it advance only on ticks where `core_awake` is high. With neither bit set, the counter holds its value.
- R6: Offset 0x08 reads the raw counter. Offset 0x10 reads the counter shifted right by settings bits [3:0] and truncated to 16 bits.
- R7: The threshold register (offset 0x20) keeps the low 16 bits of the written word and reads back with its upper bits zero.
- R8: When the scaled count is greater than or equal to the threshold, settings bit 28 (pending) is set on the next edge. It stays set until cleared, and `irq_out` follows it.
- R9: A protected settings write with bit 28 equal to 0 clears the pending flag. Writing 1 to bit 28 never sets it. A match on the same edge as a clearing write wins.
- R10: With settings bit 9 set, a match clears the counter on the next edge. With bit 9 clear, the counter continues past the threshold.
- R11: With settings bit 8 set, `rst_pulse` goes high for exactly one cycle at the start of each unbroken run of matching cycles. With bit 8 clear, `rst_pulse` stays low.
- R12: The settings register reads back bits [3:0], 8, 9, 12, 13 and 28, with every other bit zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| core_awake | input | 1 | High while the core is running; gates counting in awake mode |
| irq_out | output | 1 | Interrupt request, equal to the pending flag |
| rst_pulse | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with its default parameters: a 31-bit counter, a 16-bit threshold and a 4-bit scale. These values let small thresholds such as 3 and 4 produce matches within a few ticks. Holding the counter with both run bits clear makes counter and scaled-count reads exact. The bench then checks that the scaled-count read equals the raw count shifted by the scale. The rising edge of a match, automatic zeroing and the recurrence of matches all occur within tens of cycles, so the single-pulse reset behaviour and the sticky pending flag are observed directly.

// File: rtl/wdog_pkg.sv
// Shared constants and types for the key-protected watchdog.
// Assumes byte offsets fit in 8 bits; the top truncates them to ADDR_W.
package wdog_pkg;
    localparam logic [7:0]  OFS_CFG  = 8'h00;
    localparam logic [7:0]  OFS_CNT  = 8'h08;
    localparam logic [7:0]  OFS_SCL  = 8'h10;
    localparam logic [7:0]  OFS_FEED = 8'h18;
    localparam logic [7:0]  OFS_KEY  = 8'h1C;
    localparam logic [7:0]  OFS_CMP  = 8'h20;

    localparam logic [31:0] UNLOCK_WORD  = 32'h0051_F15E;
    localparam logic [31:0] RESTART_WORD = 32'h0D09_F00D;

    localparam int SCALE_W   = 4;
    localparam int B_RSTEN   = 8;
    localparam int B_ZERO    = 9;
    localparam int B_ALWAYS  = 12;
    localparam int B_AWAKE   = 13;
    localparam int B_PEND    = 28;

    typedef struct packed {
        logic               pend;
        logic               run_awake;
        logic               run_always;
        logic               zero_en;
        logic               rst_en;
        logic [SCALE_W-1:0] scale;
    } wd_cfg_t;
endpackage

// File: rtl/wdog_lock.sv
// Unlock gate: opened by the key word, closed by a wrong key or by any
// protected write. Assumes at most one register write per cycle.
module wdog_lock (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        key_sel,
    input  logic        prot_sel,
    input  logic [31:0] wdata,
    output logic        open_o,
    output logic        grant_o
);
    import wdog_pkg::*;

    // A protected write is granted only while the gate is open.
    assign grant_o = wr_en & prot_sel & open_o;

    // Track the gate state: key writes set or clear, protected writes consume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o <= 1'b0;
        end else if (wr_en && key_sel) begin
            open_o <= (wdata == UNLOCK_WORD);
        end else if (wr_en && prot_sel) begin
            open_o <= 1'b0;
        end
    end
endmodule

// File: rtl/wdog_cfg_regs.sv
// Settings and threshold storage plus the sticky pending flag.
// Assumes write enables are already qualified by the unlock gate.
module wdog_cfg_regs #(
    parameter int CMP_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cmp_we,
    input  wdog_pkg::wd_cfg_t    cfg_wdata,
    input  logic [CMP_W-1:0]     cmp_wdata,
    input  logic                 match,
    output wdog_pkg::wd_cfg_t    cfg_o,
    output logic [CMP_W-1:0]     cmp_o
);
    import wdog_pkg::*;

    // Store the mode, enable and scale fields on a granted settings write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o.scale      <= '0;
            cfg_o.rst_en     <= 1'b0;
            cfg_o.zero_en    <= 1'b0;
            cfg_o.run_always <= 1'b0;
            cfg_o.run_awake  <= 1'b0;
        end else if (cfg_we) begin
            cfg_o.scale      <= cfg_wdata.scale;
            cfg_o.rst_en     <= cfg_wdata.rst_en;
            cfg_o.zero_en    <= cfg_wdata.zero_en;
            cfg_o.run_always <= cfg_wdata.run_always;
            cfg_o.run_awake  <= cfg_wdata.run_awake;
        end
    end

    // Pending flag: set by a match, cleared only by writing zero; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o.pend <= 1'b0;
        end else if (match) begin
            cfg_o.pend <= 1'b1;
        end else if (cfg_we && !cfg_wdata.pend) begin
            cfg_o.pend <= 1'b0;
        end
    end

    // Threshold register, loaded on a granted threshold write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_o <= '0;
        end else if (cmp_we) begin
            cmp_o <= cmp_wdata;
        end
    end
endmodule

// File: rtl/wdog_core.sv
// Counter, power-of-two scaler, threshold comparator and reset pulse shaper.
// Assumes the restart request is already qualified by the unlock gate.
module wdog_core #(
    parameter int CNT_W = 31,
    parameter int CMP_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  wdog_pkg::wd_cfg_t    cfg,
    input  logic [CMP_W-1:0]     cmp,
    input  logic                 core_awake,
    input  logic                 restart,
    output logic [CNT_W-1:0]     cnt_o,
    output logic [CMP_W-1:0]     scaled_o,
    output logic                 match_o,
    output logic                 rst_pulse_o
);
    logic run;
    logic arm;
    logic arm_q;

    // Scaled view of the counter and the threshold comparison.
    assign scaled_o = CMP_W'(cnt_o >> cfg.scale);
    assign match_o  = (scaled_o >= cmp);
    assign run      = cfg.run_always | (cfg.run_awake & core_awake);
    assign arm      = match_o & cfg.rst_en;

    // Counter: restart first, then auto-zero on match, else advance if running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (restart) begin
            cnt_o <= '0;
        end else if (match_o && cfg.zero_en) begin
            cnt_o <= '0;
        end else if (run) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    // Emit one reset pulse on the first cycle of each armed match run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q       <= 1'b0;
            rst_pulse_o <= 1'b0;
        end else begin
            arm_q       <= arm;
            rst_pulse_o <= arm & ~arm_q;
        end
    end
endmodule

// File: rtl/wdog_keyed.sv
// Top of the key-protected watchdog: address decode, read multiplexer and
// wiring of the unlock gate, register bank and counting core.
// Assumes single-cycle register writes and combinational reads.
module wdog_keyed #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 31,
    parameter int CMP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              core_awake,
    output logic              irq_out,
    output logic              rst_pulse
);
    import wdog_pkg::*;

    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
    localparam logic [ADDR_W-1:0] A_SCL  = ADDR_W'(OFS_SCL);
    localparam logic [ADDR_W-1:0] A_FEED = ADDR_W'(OFS_FEED);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);
    localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFS_CMP);

    logic              sel_cfg, sel_feed, sel_key, sel_cmp, sel_prot;
    logic              lock_open;
    logic              grant;
    logic              restart_ok;
    logic              hit_match;
    wd_cfg_t           cfg_q;
    wd_cfg_t           cfg_in;
    logic [CMP_W-1:0]  cmp_value;
    logic [CNT_W-1:0]  cnt_value;
    logic [CMP_W-1:0]  scaled;

    // Address decode of the write targets.
    assign sel_cfg  = (reg_addr == A_CFG);
    assign sel_feed = (reg_addr == A_FEED);
    assign sel_key  = (reg_addr == A_KEY);
    assign sel_cmp  = (reg_addr == A_CMP);
    assign sel_prot = sel_cfg | sel_feed | sel_cmp;

    // Field extraction of a settings write.
    assign cfg_in.scale      = reg_wdata[SCALE_W-1:0];
    assign cfg_in.rst_en     = reg_wdata[B_RSTEN];
    assign cfg_in.zero_en    = reg_wdata[B_ZERO];
    assign cfg_in.run_always = reg_wdata[B_ALWAYS];
    assign cfg_in.run_awake  = reg_wdata[B_AWAKE];
    assign cfg_in.pend       = reg_wdata[B_PEND];

    assign restart_ok = grant & sel_feed & (reg_wdata == RESTART_WORD);
    assign irq_out    = cfg_q.pend;

    wdog_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .key_sel  (sel_key),
        .prot_sel (sel_prot),
        .wdata    (reg_wdata),
        .open_o   (lock_open),
        .grant_o  (grant)
    );

    wdog_cfg_regs #(.CMP_W(CMP_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (grant & sel_cfg),
        .cmp_we    (grant & sel_cmp),
        .cfg_wdata (cfg_in),
        .cmp_wdata (reg_wdata[CMP_W-1:0]),
        .match     (hit_match),
        .cfg_o     (cfg_q),
        .cmp_o     (cmp_value)
    );

    wdog_core #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg_q),
        .cmp         (cmp_value),
        .core_awake  (core_awake),
        .restart     (restart_ok),
        .cnt_o       (cnt_value),
        .scaled_o    (scaled),
        .match_o     (hit_match),
        .rst_pulse_o (rst_pulse)
    );

    // Read multiplexer over the register offsets.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG: begin
                reg_rdata[SCALE_W-1:0] = cfg_q.scale;
                reg_rdata[B_RSTEN]     = cfg_q.rst_en;
                reg_rdata[B_ZERO]      = cfg_q.zero_en;
                reg_rdata[B_ALWAYS]    = cfg_q.run_always;
                reg_rdata[B_AWAKE]     = cfg_q.run_awake;
                reg_rdata[B_PEND]      = cfg_q.pend;
            end
            A_CNT:   reg_rdata = 32'(cnt_value);
            A_SCL:   reg_rdata = 32'(scaled);
            A_KEY:   reg_rdata = {31'b0, lock_open};
            A_CMP:   reg_rdata = 32'(cmp_value);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_keyed_chk.sv
// Temporal checks on the watchdog, bound into every wdog_keyed instance.
// Assumes it is connected to the top's internal gate, match and state nets.
module wdog_keyed_chk #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 31,
    parameter int CMP_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              irq_out,
    input logic              rst_pulse,
    input logic              lock_open,
    input logic              hit_match,
    input logic [CNT_W-1:0]  cnt_value,
    input logic [CMP_W-1:0]  cmp_value
);
    import wdog_pkg::*;

    logic prot_wr;
    assign prot_wr = reg_wr && (reg_addr == ADDR_W'(OFS_CFG) ||
                                reg_addr == ADDR_W'(OFS_FEED) ||
                                reg_addr == ADDR_W'(OFS_CMP));

    assert_unlock_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr |=> !lock_open);

    assert_locked_cmp_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_CMP) && !lock_open) |=> $stable(cmp_value));

    assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_FEED) && reg_wdata == RESTART_WORD && lock_open)
        |=> (cnt_value == '0));

    assert_match_sets_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_match |=> irq_out);

    assert_irq_falls_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_out) |-> $past(reg_wr && reg_addr == ADDR_W'(OFS_CFG) && lock_open
                                 && !reg_wdata[B_PEND]));

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);

    assert_pulse_after_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> $past(hit_match));
endmodule

bind wdog_keyed wdog_keyed_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CMP_W(CMP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_out   (irq_out),
    .rst_pulse (rst_pulse),
    .lock_open (lock_open),
    .hit_match (hit_match),
    .cnt_value (cnt_value),
    .cmp_value (cmp_value)
);

// File: tb/test_wdog_keyed.sv
`timescale 1ns/1ps
module test_wdog_keyed;
    localparam int ADDR_W = 8;
    localparam logic [31:0] KEYW = 32'h0051_F15E;
    localparam logic [31:0] FEEDW = 32'h0D09_F00D;
    localparam logic [7:0] A_CFG = 8'h00, A_CNT = 8'h08, A_SCL = 8'h10,
                           A_FEED = 8'h18, A_KEY = 8'h1C, A_CMP = 8'h20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              core_awake = 1'b0;
    logic              irq_out;
    logic              rst_pulse;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdog_keyed i_wdog_keyed (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_awake(core_awake),
        .irq_out(irq_out), .rst_pulse(rst_pulse)
    );

    // Vector: {is_read, requirement, offset, data-or-expected}
    localparam int NV = 21;
    localparam logic [47:0] VEC [NV] = '{
        {1'b1, 7'd2,  A_KEY, 32'h0},          // R2 closed after reset
        {1'b0, 7'd2,  A_KEY, KEYW},
        {1'b1, 7'd2,  A_KEY, 32'h1},          // R2 open
        {1'b0, 7'd7,  A_CMP, 32'hABCD_1234},
        {1'b1, 7'd3,  A_KEY, 32'h0},          // R3 consumed
        {1'b1, 7'd7,  A_CMP, 32'h0000_1234},  // R7 16-bit readback
        {1'b0, 7'd3,  A_CMP, 32'h0000_0055},
        {1'b1, 7'd3,  A_CMP, 32'h0000_1234},  // R3 locked write ignored
        {1'b0, 7'd2,  A_KEY, KEYW},
        {1'b0, 7'd2,  A_KEY, 32'h1234_5678},
        {1'b1, 7'd2,  A_KEY, 32'h0},          // R2 wrong key closes
        {1'b0, 7'd12, A_KEY, KEYW},
        {1'b0, 7'd12, A_CFG, 32'hEFFF_EFFF},
        {1'b1, 7'd12, A_CFG, 32'h0000_230F},  // R12 field readback
        {1'b0, 7'd6,  A_SCL, 32'h0000_FFFF},
        {1'b1, 7'd6,  A_CNT, 32'h0},          // R6 count held at zero
        {1'b0, 7'd3,  A_KEY, KEYW},
        {1'b0, 7'd3,  A_CNT, 32'h0000_0055},
        {1'b1, 7'd3,  A_KEY, 32'h1},          // R3 read-only write keeps unlock
        {1'b0, 7'd12, A_CFG, 32'h0},
        {1'b1, 7'd12, A_CFG, 32'h0}           // R12 cleared
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pwr(input logic [7:0] a, input logic [31:0] d);
        wr(A_KEY, KEYW);
        wr(a, d);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        logic [31:0] a, b, c, s;
        int pulses, maxc;
        repeat (4) @(negedge clk);
        // R1 reset state
        rst_n = 1'b0;
        rd(A_CFG, a); check("R1 cfg", a, 32'h0);
        rd(A_CNT, a); check("R1 cnt", a, 32'h0);
        check("R1 irq", {31'b0, irq_out}, 32'h0);
        check("R1 rst", {31'b0, rst_pulse}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_KEY, a); check("R1 key", a, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][47]) begin
                rd(VEC[i][39:32], a);
                check($sformatf("R%0d vector %0d", VEC[i][46:40], i), a, VEC[i][31:0]);
            end else begin
                wr(VEC[i][39:32], VEC[i][31:0]);
            end
        end

        // R5 run always
        pwr(A_CFG, 32'h0000_1000);
        rd(A_CNT, a); repeat (10) @(negedge clk); rd(A_CNT, b);
        check("R5 always", b - a, 32'd10);
        // R5 awake only, core asleep then awake
        pwr(A_CFG, 32'h0000_2000);
        rd(A_CNT, a); repeat (10) @(negedge clk); rd(A_CNT, b);
        check("R5 asleep", b - a, 32'd0);
        core_awake = 1'b1;
        rd(A_CNT, a); repeat (10) @(negedge clk); rd(A_CNT, b);
        check("R5 awake", b - a, 32'd10);
        core_awake = 1'b0;
        pwr(A_CFG, 32'h0);
        core_awake = 1'b1;
        rd(A_CNT, a); repeat (10) @(negedge clk); rd(A_CNT, b);
        check("R5 neither", b - a, 32'd0);
        core_awake = 1'b0;

        // R4 restart protocol
        wr(A_FEED, FEEDW);
        rd(A_CNT, c); check("R4 locked restart", c, b);
        pwr(A_FEED, 32'h1234_5678);
        rd(A_CNT, c); check("R4 wrong word", c, b);
        pwr(A_FEED, FEEDW);
        rd(A_CNT, c); check("R4 restart", c, 32'h0);

        // R6 scaled view
        pwr(A_CFG, 32'h0000_1003);
        repeat (100) @(negedge clk);
        pwr(A_CFG, 32'h0000_0003);
        rd(A_CNT, c); rd(A_SCL, s);
        check("R6 scaled", s, (c >> 3) & 32'hFFFF);
        check("R6 count grew", {31'b0, c >= 32'd100}, 32'h1);

        // R8 / R10 match with auto-zero
        pwr(A_FEED, FEEDW);
        pwr(A_CMP, 32'h4);
        pwr(A_CFG, 32'h0000_1200);
        maxc = 0;
        for (int k = 0; k < 30; k++) begin
            rd(A_CNT, c);
            if (int'(c) > maxc) maxc = int'(c);
            @(negedge clk);
        end
        check("R10 auto-zero max", maxc, 32'd4);
        check("R8 irq", {31'b0, irq_out}, 32'h1);
        rd(A_CFG, a); check("R8 pending bit", a, 32'h1000_1200);
        // R9 clear rules
        wr(A_CFG, 32'h0);
        check("R9 locked clear", {31'b0, irq_out}, 32'h1);
        pwr(A_CFG, 32'h1000_0000);
        pwr(A_FEED, FEEDW);
        pwr(A_CFG, 32'h0);
        check("R9 cleared", {31'b0, irq_out}, 32'h0);
        pwr(A_CFG, 32'h1000_0000);
        check("R9 write one", {31'b0, irq_out}, 32'h0);

        // R11 reset pulse, R10 no auto-zero
        pwr(A_CMP, 32'h3);
        pwr(A_CFG, 32'h0000_1100);
        pulses = 0;
        for (int k = 0; k < 40; k++) begin
            if (rst_pulse) pulses++;
            @(negedge clk);
        end
        check("R11 one pulse", pulses, 32'd1);
        rd(A_CNT, c);
        check("R10 passes threshold", {31'b0, c > 32'd3}, 32'h1);
        pwr(A_CFG, 32'h0);
        pwr(A_FEED, FEEDW);
        pwr(A_CFG, 32'h0000_1000);
        pulses = 0;
        for (int k = 0; k < 40; k++) begin
            if (rst_pulse) pulses++;
            @(negedge clk);
        end
        check("R11 disabled", pulses, 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule